// File: doc/BRIEF.md
# Power-of-Two Shifted-Term Precompute Unit

This unit sits at the front of a multiplier-free convolution datapath whose weights are sums of signed powers of two. Each accepted activation is turned at once into every term such a weight could need. For each shift amount the unit produces an arithmetic right shift of the activation and the two's complement negation of that shift. A downstream selector then only has to pick stored terms. No multiply or per-weight shift is needed after this point.

The weight format is set by two parameters: the index width per sub-codebook (B) and the number of sub-codebooks (N). Each sub-codebook holds 2^B − 1 values, zero among them. The number of distinct terms is P = (2^B − 1) + 2(N − 1). The zero term is never stored, so the buffer holds P − 1 terms, which is always an even number. They are split into (P − 1)/2 shift amounts, each in a positive and a negative form.

Each stored term has its own shift-register array, and every array is as deep as the number of input channels. Every valid activation moves all arrays by one slot together. The whole buffer is visible at all times on one flat read bus. A ready flag reports that a full set of channels has been loaded.

Top module: `pot_precompute_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every entry of the buffer is cleared to zero and `buf_ready` is low from the next edge.
- R2: Term index 2s (for s from 0 to (P−1)/2 − 1) holds the activation sign-extended to DATA_W+1 bits and shifted arithmetically right by s. The result rounds toward negative infinity, so −7 shifted by 1 gives −4.
- R3: Term index 2s+1 holds the two's complement negation of term 2s in DATA_W+1 bits. An input of −128 (8-bit default) therefore gives +128 with no overflow.
- R4: At a clock edge with `in_valid` high, the new terms enter slot 0 of every array, slot j takes the old slot j−1, and the old value in the last slot is dropped.
- R5: At a clock edge with `in_valid` low, no buffer entry changes.
- R6: `buf_ready` rises right after the edge that accepts the CHANNELS-th valid activation since reset. It stays low before that edge and stays high until the next reset.
- R7: Read-bus layout: the entry for term k, slot j occupies `buf_terms[(k*CHANNELS + j)*(DATA_W+1) +: DATA_W+1]`. With the defaults (B=2, N=2) there are 4 terms, covering shifts 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_act` for this cycle |
| in_act | input | DATA_W | Signed input activation |
| buf_ready | output | 1 | A full channel set has been loaded |
| buf_terms | output | NUM_TERM*CHANNELS*(DATA_W+1) | Every stored term for every slot |

## Verification
The term computation is driven with positive, negative, odd and even activations. Odd negative values separate floor rounding from truncation toward zero, and the most negative input and the largest positive input expose a negation held at too narrow a width. The values 1, −1 and 0 show whether the shifted terms sign-extend or collapse to zero. Checking the slots behind slot 0 after each load confirms that all arrays move together and that the oldest entry drops out. Idle gaps and a mid-run reset exercise the hold behaviour and the ready flag.

// File: rtl/pot_pre_pkg.sv
package pot_pre_pkg;

  // Stored terms per activation: all nonzero entries of the combined codebook set
  function automatic int stored_terms(input int idx_bits, input int n_sub);
    int m;
    int p;
    m = (1 << idx_bits) - 1;
    p = m + 2 * (n_sub - 1);
    return p - 1;
  endfunction

endpackage

// File: rtl/pot_term_gen.sv
module pot_term_gen #(
  parameter int DATA_W    = 8,
  parameter int NUM_SHIFT = 2,
  localparam int TW       = DATA_W + 1,
  localparam int NUM_TERM = 2 * NUM_SHIFT
) (
  input  logic [DATA_W-1:0]               act,
  output logic [NUM_TERM-1:0][TW-1:0]     terms
);

  logic signed [TW-1:0] act_ext;
  assign act_ext = $signed({act[DATA_W-1], act});

  for (genvar s = 0; s < NUM_SHIFT; s++) begin : g_shift
    logic signed [TW-1:0] pos_t;
    logic signed [TW-1:0] neg_t;
    assign pos_t = act_ext >>> s;
    assign neg_t = -pos_t;
    assign terms[2*s]   = pos_t;
    assign terms[2*s+1] = neg_t;
  end

endmodule

// File: rtl/term_shift_array.sv
module term_shift_array #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift_en,
  input  logic [WIDTH-1:0]            din,
  output logic [DEPTH-1:0][WIDTH-1:0] slots
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slots <= '0;
    end else if (shift_en) begin
      slots[0] <= din;
      for (int j = 1; j < DEPTH; j++) begin
        slots[j] <= slots[j-1];
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(slots)); // R5

  if (DEPTH > 1) begin : g_move_chk
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> slots[1] == $past(slots[0])); // R4
  end

endmodule

// File: rtl/load_counter.sv
module load_counter #(
  parameter int LIMIT = 4,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic full
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (load && cnt != CW'(LIMIT)) begin
      cnt  <= cnt + 1'b1;
      if (cnt == CW'(LIMIT - 1)) full <= 1'b1;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    full |=> full); // R6

  AST_READY_COUNT: assert property (@(posedge clk) disable iff (rst)
    !full |-> cnt < CW'(LIMIT)); // R6

endmodule

// File: rtl/pot_precompute_unit.sv
module pot_precompute_unit
  import pot_pre_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDX_BITS  = 2,
  parameter int NUM_SUB   = 2,
  parameter int CHANNELS  = 4,
  localparam int TW        = DATA_W + 1,
  localparam int NUM_TERM  = stored_terms(IDX_BITS, NUM_SUB),
  localparam int NUM_SHIFT = NUM_TERM / 2,
  localparam int BUS_W     = NUM_TERM * CHANNELS * TW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_act,
  output logic              buf_ready,
  output logic [BUS_W-1:0]  buf_terms
);

  logic [NUM_TERM-1:0][TW-1:0]               new_terms;
  logic [NUM_TERM-1:0][CHANNELS-1:0][TW-1:0] arr_out;

  pot_term_gen #(
    .DATA_W    (DATA_W),
    .NUM_SHIFT (NUM_SHIFT)
  ) u_gen (
    .act   (in_act),
    .terms (new_terms)
  );

  for (genvar k = 0; k < NUM_TERM; k++) begin : g_arr
    term_shift_array #(
      .WIDTH (TW),
      .DEPTH (CHANNELS)
    ) u_arr (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .din      (new_terms[k]),
      .slots    (arr_out[k])
    );
    for (genvar j = 0; j < CHANNELS; j++) begin : g_slot
      assign buf_terms[(k*CHANNELS + j)*TW +: TW] = arr_out[k][j];
    end
  end

  load_counter #(
    .LIMIT (CHANNELS)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .full (buf_ready)
  );

  AST_NEWEST_UNSHIFTED: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> arr_out[0][0] == $past({in_act[DATA_W-1], in_act})); // R2

  for (genvar s = 0; s < NUM_SHIFT; s++) begin : g_pair_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> TW'(arr_out[2*s][0] + arr_out[2*s+1][0]) == '0); // R3
  end

endmodule

// File: tb/pot_precompute_unit_test.sv
module pot_precompute_unit_test;

  localparam int DW  = 8;
  localparam int C   = 4;
  localparam int TW  = DW + 1;
  localparam int NT  = 4;
  localparam int NV  = 8;
  localparam int BW  = NT * C * TW;

  // stimulus and expected terms: {+x, -x, +(x>>>1), -(x>>>1)}
  localparam logic signed [DW-1:0] VX [NV] = '{100, -7, -128, 127, 1, -1, 0, -3};
  localparam logic signed [TW-1:0] VE [NV][NT] = '{
    '{100, -100, 50, -50},
    '{-7, 7, -4, 4},
    '{-128, 128, -64, 64},
    '{127, -127, 63, -63},
    '{1, -1, 0, 0},
    '{-1, 1, -1, 1},
    '{0, 0, 0, 0},
    '{-3, 3, -2, 2}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_act = '0;
  logic          buf_ready;
  logic [BW-1:0] buf_terms;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pot_precompute_unit uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_act    (in_act),
    .buf_ready (buf_ready),
    .buf_terms (buf_terms)
  );

  function automatic logic [TW-1:0] entry(input int k, input int j);
    return buf_terms[(k*C + j)*TW +: TW];
  endfunction

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic load(input logic [DW-1:0] x);
    @(negedge clk);
    in_valid = 1'b1;
    in_act   = x;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [BW-1:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 bus zero", TW'(buf_terms != '0), '0);
    check("R1 ready low", TW'(buf_ready), '0);

    // table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      load(VX[i]);
      for (int k = 0; k < NT; k++) begin
        check(k[0] ? "R3 negated term" : "R2 shifted term", entry(k, 0), VE[i][k]);
        if (i >= 1) check("R4 slot1 follows", entry(k, 1), VE[i-1][k]);
      end
      check("R6 ready", TW'(buf_ready), TW'(i >= C - 1));
    end
    // R4: oldest dropped, last slot holds vector NV-C
    for (int k = 0; k < NT; k++) check("R4 last slot", entry(k, C - 1), VE[NV-C][k]);

    // R5: idle cycles leave buffer unchanged
    snap = buf_terms;
    in_act = 8'h55;
    repeat (5) @(negedge clk);
    check("R5 hold", TW'(buf_terms != snap), '0);
    check("R6 ready sticky", TW'(buf_ready), 1);

    // R1: mid-run reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 bus cleared", TW'(buf_terms != '0), '0);
    check("R1 ready cleared", TW'(buf_ready), '0);

    // R6: ready only after the C-th load
    for (int i = 0; i < C - 1; i++) load(VX[i]);
    check("R6 low before full", TW'(buf_ready), '0);
    load(VX[C-1]);
    check("R6 high at full", TW'(buf_ready), 1);
    // R7: slot ordering after a fresh fill, slot j holds load C-1-j
    for (int j = 0; j < C; j++) check("R7 layout", entry(2, j), VE[C-1-j][2]);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule